// File: doc/BRIEF.md
# Per-Line Source Identification Serializer

This block produces the serial identification stream that a video inserter places on chosen lines. Two static configuration groups together form an identification word. At the start of each video line, a load strobe taken from the horizontal timing copies that word into a shift register. On every falling edge of the identification clock, the register advances by one position, and the most significant bit leaves first. The current head bit is ANDed with the identification clock level and registered on the fast sampling clock, which runs at eight times the subcarrier rate. The result is a serial bit that is high only in the clock-high part of each bit cell in which the head bit is 1.

The same load strobe also samples a per-line select input. The registered select becomes an enable output for the whole line. Downstream, this enable hands the edge-shaping state machine over to the serial bit. The horizontal counter decodes and the analog shaping stay outside this block. All strobes arrive as levels or single-cycle pulses synchronous to the sampling clock.

Top module: `srcid_serializer`

## Requirements
- R1: After synchronous reset, `id_bit` and `id_en` are 0.
- R2: A `line_load` pulse captures the word {`cfg_upper`, `cfg_lower`}, with `cfg_upper` in bits 15:8. Bit 15 is the first bit transmitted.
- R3: A high-to-low transition of `id_clk`, seen between two consecutive sampling clock cycles, shifts the word toward the MSB by one position. The head bit is always bit 15 of the word.
- R4: On each sampling clock edge, `id_bit` takes the value (head bit AND `id_clk`) from before that edge. It is therefore 0 in the cycle after any cycle with `id_clk` low.
- R5: After 16 shifts following a load, the head bit is 0. `id_bit` then stays 0 until the next load.
- R6: When `line_load` coincides with an `id_clk` falling transition, the load wins: the new word is intact and its bit 15 is sent first.
- R7: `id_en` takes the value of `line_sel` at each `line_load`. It ignores changes of `line_sel` between loads.
- R8: While `id_clk` stays high, no shift happens and `id_bit` keeps presenting the same head bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, eight times the subcarrier rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_upper | input | 8 | Upper configuration group, word bits 15:8 |
| cfg_lower | input | 8 | Lower configuration group, word bits 7:0 |
| line_load | input | 1 | Once-per-line load strobe (single-cycle pulse) |
| id_clk | input | 1 | Identification clock level |
| line_sel | input | 1 | Line wants identification insertion |
| id_bit | output | 1 | Gated, resampled serial identification bit |
| id_en | output | 1 | Hands the shaping state machine to `id_bit` for this line |

## Verification
The word is swept through all-zeros, all-ones, alternating patterns and every one-hot position. This sweep separates a wrong bit order, a swapped group order and a stuck shift position. Each bit cell is sampled in both its clock-high and clock-low halves, which shows whether gating takes place before the resampling register. A long train of extra identification clock cycles after the sixteenth bit separates zero-filling from rotation. A held-high clock shows whether shifting is tied to the falling transition rather than the level. A load placed on a falling transition shows whether load or shift has priority. Changing the line select mid-line shows whether the enable is sampled only at the load.

// File: rtl/srcid_pkg.sv
package srcid_pkg;

    localparam int unsigned GROUP_BITS_DEF = 8;

    typedef enum logic {
        LINE_PLAIN = 1'b0,
        LINE_IDENT = 1'b1
    } line_mode_e;

    typedef struct packed {
        logic shift;
        logic gated;
    } gate_ctl_t;

    function automatic logic fall_seen(input logic prev, input logic now);
        return prev && !now;
    endfunction

endpackage

// File: rtl/srcid_shreg.sv
module srcid_shreg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         head
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_word;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], 1'b0};
        end
    end

    assign head = sr_q[W-1];

    p_load_wins_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> (sr_q == $past(load_word)));

    p_shift_step_r3: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (sr_q == {$past(sr_q[W-2:0]), 1'b0}));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!shift && !load) |=> $stable(sr_q));

endmodule

// File: rtl/srcid_gate.sv
module srcid_gate
    import srcid_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic id_clk,
    input  logic head,
    output logic shift,
    output logic id_bit
);
    logic      id_clk_q;
    gate_ctl_t ctl;

    always_comb begin
        ctl.shift = fall_seen(id_clk_q, id_clk);
        ctl.gated = head & id_clk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            id_clk_q <= 1'b0;
            id_bit   <= 1'b0;
        end else begin
            id_clk_q <= id_clk;
            id_bit   <= ctl.gated;
        end
    end

    assign shift = ctl.shift;

    p_gate_low_r4: assert property (@(posedge clk) disable iff (rst)
        !id_clk |=> !id_bit);

    p_gate_pass_r4: assert property (@(posedge clk) disable iff (rst)
        id_clk |=> (id_bit == $past(head)));

    p_shift_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        shift |-> !id_clk);

endmodule

// File: rtl/srcid_linectl.sv
module srcid_linectl
    import srcid_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic line_sel,
    output logic id_en
);
    line_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= LINE_PLAIN;
        end else if (load) begin
            mode_q <= line_sel ? LINE_IDENT : LINE_PLAIN;
        end
    end

    assign id_en = (mode_q == LINE_IDENT);

    p_en_held_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(id_en));

    p_en_sampled_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> (id_en == $past(line_sel)));

endmodule

// File: rtl/srcid_serializer.sv
module srcid_serializer
    import srcid_pkg::*;
#(
    parameter int unsigned GROUP_W = GROUP_BITS_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [GROUP_W-1:0] cfg_upper,
    input  logic [GROUP_W-1:0] cfg_lower,
    input  logic               line_load,
    input  logic               id_clk,
    input  logic               line_sel,
    output logic               id_bit,
    output logic               id_en
);
    localparam int unsigned ID_W = 2 * GROUP_W;

    logic [ID_W-1:0] word;
    logic            head;
    logic            shift;

    assign word = {cfg_upper, cfg_lower};

    srcid_shreg #(.W(ID_W)) u_shreg (
        .clk       (clk),
        .rst       (rst),
        .load      (line_load),
        .load_word (word),
        .shift     (shift),
        .head      (head)
    );

    srcid_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .id_clk (id_clk),
        .head   (head),
        .shift  (shift),
        .id_bit (id_bit)
    );

    srcid_linectl u_linectl (
        .clk      (clk),
        .rst      (rst),
        .load     (line_load),
        .line_sel (line_sel),
        .id_en    (id_en)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!id_bit && !id_en));

endmodule

// File: tb/srcid_serializer_test.sv
module srcid_serializer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_upper = '0;
    logic [7:0] cfg_lower = '0;
    logic       line_load = 1'b0;
    logic       id_clk = 1'b0;
    logic       line_sel = 1'b0;
    logic       id_bit;
    logic       id_en;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    srcid_serializer uut (
        .clk(clk), .rst(rst), .cfg_upper(cfg_upper), .cfg_lower(cfg_lower),
        .line_load(line_load), .id_clk(id_clk), .line_sel(line_sel),
        .id_bit(id_bit), .id_en(id_en)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic load_line(input logic [15:0] w, input logic sel);
        cfg_upper = w[15:8];
        cfg_lower = w[7:0];
        line_sel  = sel;
        line_load = 1'b1;
        id_clk    = 1'b0;
        step();
        line_load = 1'b0;
        chk("R7 enable sampled", int'(id_en), int'(sel));
    endtask

    task automatic run_line(input logic [15:0] w, input logic sel);
        load_line(w, sel);
        line_sel = ~sel;
        for (int i = 0; i < 16; i++) begin
            id_clk = 1'b1;
            step();
            chk("R2/R3 bit order", int'(id_bit), int'(w[15-i]));
            id_clk = 1'b0;
            step();
            chk("R4 gated low", int'(id_bit), 0);
        end
        for (int k = 0; k < 4; k++) begin
            id_clk = 1'b1;
            step();
            chk("R5 zero fill", int'(id_bit), 0);
            id_clk = 1'b0;
            step();
        end
        chk("R7 enable held", int'(id_en), int'(sel));
    endtask

    initial begin
        repeat (3) step();
        chk("R1 id_bit reset", int'(id_bit), 0);
        chk("R1 id_en reset", int'(id_en), 0);
        rst = 1'b0;
        step();

        run_line(16'h0000, 1'b0);
        run_line(16'hFFFF, 1'b1);
        run_line(16'hA5C3, 1'b1);
        run_line(16'h5A3C, 1'b0);
        run_line(16'h8001, 1'b1);
        for (int p = 0; p < 16; p++) begin
            run_line(16'(1) << p, p[0]);
        end

        // R8: clock held high, no shift
        load_line(16'hB000, 1'b1);
        id_clk = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R8 held high", int'(id_bit), 1);
        end
        id_clk = 1'b0;
        step();
        id_clk = 1'b1;
        step();
        chk("R8 next bit after fall", int'(id_bit), 0);
        id_clk = 1'b0;
        step();
        id_clk = 1'b1;
        step();
        chk("R8 third bit", int'(id_bit), 1);

        // R6: load coincident with falling edge
        load_line(16'h4000, 1'b0);
        id_clk = 1'b1;
        step();
        chk("R6 first word head", int'(id_bit), 0);
        cfg_upper = 8'h3F;
        cfg_lower = 8'hFF;
        line_load = 1'b1;
        id_clk    = 1'b0;
        step();
        line_load = 1'b0;
        id_clk = 1'b1;
        step();
        chk("R6 load wins head", int'(id_bit), 0);
        id_clk = 1'b0;
        step();
        id_clk = 1'b1;
        step();
        chk("R6 load wins bit14", int'(id_bit), 0);
        id_clk = 1'b0;
        step();
        id_clk = 1'b1;
        step();
        chk("R6 load wins bit13", int'(id_bit), 1);
        id_clk = 1'b0;
        step();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule